// File: doc/BRIEF.md
# 32-bit Integer Arithmetic and Logic Unit

This block is the purely combinational arithmetic and logic unit of a simple load/store integer datapath. It takes two 32-bit operands and a 4-bit operation code. In the same cycle it returns a 32-bit result together with carry, signed-overflow and zero flags. Upstream logic does all instruction decode, immediate extension and register reads, so the unit sees only operands and a code.

One adder serves both addition and subtraction. For subtraction, operand B passes through a 2:1 inverting multiplexer and the adder's carry-in is forced to 1, so the adder computes A + ~B + 1. The adder is split into fixed-width lookahead groups, and the groups are joined by a carry chain. Both set-less-than operations reuse the subtractor. The signed compare takes the sign of the difference corrected by the overflow term. The unsigned compare takes the borrow. The zero flag is a wide NOR over the result, so a subtract can drive equal or not-equal branch decisions.

The block sits between combinational pipeline stages and has no flow control, so it uses no valid/ready handshake. A new operand set gives a new result after the combinational delay.

Top module: `int_alu`

## Requirements
- R1: Codes 0000 (signed add) and 0001 (unsigned add) give result = (A + B) mod 2^32. For these codes, carry equals bit 32 of the full sum.
- R2: Codes 0010 (signed subtract) and 0011 (unsigned subtract) give result = (A - B) mod 2^32. For these codes, carry is 1 exactly when A >= B as unsigned numbers, meaning no borrow.
- R3: The overflow flag is 1 for codes 0000 and 0010 exactly when the signed result cannot be represented. For addition this happens only when both operands have the same sign and the result has the other sign. Codes 0001 and 0011 always drive overflow to 0.
- R4: Code 0100 gives A AND B, 0101 gives A OR B, 0110 gives A XOR B, and 0111 gives NOT (A OR B).
- R5: Code 1010 gives 1 when A < B as two's-complement numbers and 0 otherwise. The value is placed in bit 0 and bits 31:1 are 0. The answer stays correct when A - B overflows.
- R6: Code 1011 gives 1 in bit 0 when A < B as unsigned numbers and 0 otherwise, with bits 31:1 equal to 0.
- R7: For every defined code, the zero flag is 1 exactly when all 32 result bits are 0.
- R8: For the logic codes (0100 to 0111) and the compare codes (1010, 1011), carry and overflow are 0.
- R9: The unused codes 1000, 1001 and 1100 to 1111 give result 0 with carry, overflow and zero all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (A) |
| op_b | input | 32 | Second operand (B) |
| op_code | input | 4 | Operation select |
| result | output | 32 | Operation result (S) |
| carry | output | 1 | Carry out of bit 31 for add and subtract codes |
| overflow | output | 1 | Signed overflow for signed add and subtract |
| zero | output | 1 | Result is all zeros (defined codes only) |

## Verification
The assertions assume that op_code and both operands are driven with known values once the inputs have settled. The assertions are evaluated on combinational changes, so they also assume that no check is sampled while an input is partly updated. The bench meets both assumptions: every input changes together at a clock edge and is checked half a period later. Random operands are drawn over the full 32-bit range for all sixteen codes, which include the unused ones. Directed vectors add the signed-overflow boundaries, equal operands, all-ones operands, and compares whose subtraction overflows.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_ADDU = 4'b0001,
    OP_SUB  = 4'b0010,
    OP_SUBU = 4'b0011,
    OP_AND  = 4'b0100,
    OP_OR   = 4'b0101,
    OP_XOR  = 4'b0110,
    OP_NOR  = 4'b0111,
    OP_SLT  = 4'b1010,
    OP_SLTU = 4'b1011
  } alu_op_e;

  typedef enum logic [1:0] {
    LU_AND = 2'b00,
    LU_OR  = 2'b01,
    LU_XOR = 2'b10,
    LU_NOR = 2'b11
  } logic_fn_e;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'b00,
    SEL_ARITH = 2'b01,
    SEL_LOGIC = 2'b10,
    SEL_CMP   = 2'b11
  } res_sel_e;

  typedef struct packed {
    logic      invert_b;
    logic      force_cin;
    logic      signed_arith;
    logic      cmp_unsigned;
    res_sel_e  sel;
    logic_fn_e lfn;
  } alu_ctl_t;

endpackage

// File: rtl/alu_ctl_decode.sv
module alu_ctl_decode
  import alu_pkg::*;
(
  input  logic [3:0] op_code,
  output alu_ctl_t   ctl
);

  always_comb begin
    ctl = '{invert_b: 1'b0, force_cin: 1'b0, signed_arith: 1'b0,
            cmp_unsigned: 1'b0, sel: SEL_NONE, lfn: LU_AND};
    unique case (op_code)
      OP_ADD:  begin ctl.sel = SEL_ARITH; ctl.signed_arith = 1'b1; end
      OP_ADDU: begin ctl.sel = SEL_ARITH; end
      OP_SUB:  begin
        ctl.sel = SEL_ARITH; ctl.signed_arith = 1'b1;
        ctl.invert_b = 1'b1; ctl.force_cin = 1'b1;
      end
      OP_SUBU: begin
        ctl.sel = SEL_ARITH; ctl.invert_b = 1'b1; ctl.force_cin = 1'b1;
      end
      OP_AND:  begin ctl.sel = SEL_LOGIC; ctl.lfn = LU_AND; end
      OP_OR:   begin ctl.sel = SEL_LOGIC; ctl.lfn = LU_OR;  end
      OP_XOR:  begin ctl.sel = SEL_LOGIC; ctl.lfn = LU_XOR; end
      OP_NOR:  begin ctl.sel = SEL_LOGIC; ctl.lfn = LU_NOR; end
      OP_SLT:  begin
        ctl.sel = SEL_CMP; ctl.invert_b = 1'b1; ctl.force_cin = 1'b1;
      end
      OP_SLTU: begin
        ctl.sel = SEL_CMP; ctl.invert_b = 1'b1; ctl.force_cin = 1'b1;
        ctl.cmp_unsigned = 1'b1;
      end
      default: ctl.sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/alu_cla_adder.sv
module alu_cla_adder #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             msb_cin
);

  localparam int NGRP = WIDTH / GROUP;

  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] carry_vec;
  logic [NGRP:0]    grp_c;

  assign prop     = a ^ b;
  assign gen      = a & b;
  assign grp_c[0] = cin;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    logic [GROUP-1:0] gp;
    logic [GROUP-1:0] gg;
    logic [GROUP-1:0] lc;
    logic             blk_g;
    logic             blk_p;

    assign gp = prop[gi*GROUP +: GROUP];
    assign gg = gen[gi*GROUP +: GROUP];

    // Each internal carry as a flat sum of products of the group carry-in
    always_comb begin
      logic acc;
      logic term;
      for (int i = 0; i < GROUP; i++) begin
        acc = grp_c[gi];
        for (int j = 0; j < i; j++) acc = acc & gp[j];
        for (int k = 0; k < i; k++) begin
          term = gg[k];
          for (int j = k + 1; j < i; j++) term = term & gp[j];
          acc = acc | term;
        end
        lc[i] = acc;
      end
      blk_p = &gp;
      blk_g = 1'b0;
      for (int k = 0; k < GROUP; k++) begin
        term = gg[k];
        for (int j = k + 1; j < GROUP; j++) term = term & gp[j];
        blk_g = blk_g | term;
      end
    end

    assign grp_c[gi+1]                 = blk_g | (blk_p & grp_c[gi]);
    assign carry_vec[gi*GROUP +: GROUP] = lc;
  end

  assign sum     = prop ^ carry_vec;
  assign cout    = grp_c[NGRP];
  assign msb_cin = carry_vec[WIDTH-1];

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic_fn_e        fn,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    unique case (fn)
      LU_AND:  y = a & b;
      LU_OR:   y = a | b;
      LU_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       op_code,
  output logic [WIDTH-1:0] result,
  output logic             carry,
  output logic             overflow,
  output logic             zero
);

  alu_ctl_t         ctl;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] lres;
  logic             add_cout;
  logic             add_msb_cin;
  logic             raw_ovf;
  logic             less;

  alu_ctl_decode u_dec (.op_code(op_code), .ctl(ctl));

  assign b_eff = ctl.invert_b ? ~op_b : op_b;

  alu_cla_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) u_add (
    .a(op_a), .b(b_eff), .cin(ctl.force_cin),
    .sum(sum), .cout(add_cout), .msb_cin(add_msb_cin)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_lu (
    .a(op_a), .b(op_b), .fn(ctl.lfn), .y(lres)
  );

  assign raw_ovf = add_msb_cin ^ add_cout;
  assign less    = ctl.cmp_unsigned ? ~add_cout : (sum[WIDTH-1] ^ raw_ovf);

  always_comb begin
    result   = '0;
    carry    = 1'b0;
    overflow = 1'b0;
    unique case (ctl.sel)
      SEL_ARITH: begin
        result   = sum;
        carry    = add_cout;
        overflow = ctl.signed_arith & raw_ovf;
      end
      SEL_LOGIC: result = lres;
      SEL_CMP:   result = {{(WIDTH-1){1'b0}}, less};
      default:   result = '0;
    endcase
    zero = (ctl.sel != SEL_NONE) & ~(|result);
  end

endmodule

// File: rtl/alu_checker.sv
module alu_checker
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] result,
  input logic             carry,
  input logic             overflow,
  input logic             zero
);

  logic defined_op;
  logic logic_or_cmp;
  assign defined_op   = (op_code <= 4'd7) || (op_code == 4'd10) || (op_code == 4'd11);
  assign logic_or_cmp = (op_code inside {[4'd4:4'd7]}) || (op_code == 4'd10) || (op_code == 4'd11);

  always_comb begin
    if (!$isunknown({op_a, op_b, op_code})) begin
      AST_NO_UNSIGNED_OVF: assert (!((op_code == 4'd1 || op_code == 4'd3) && overflow))
        else $error("unsigned overflow raised"); // R3
      AST_ADD_OVF_SIGNS: assert (!(op_code == 4'd0 && overflow) ||
                                 (op_a[WIDTH-1] == op_b[WIDTH-1] && result[WIDTH-1] != op_a[WIDTH-1]))
        else $error("add overflow with inconsistent signs"); // R3
      AST_SUB_OVF_SIGNS: assert (!(op_code == 4'd2 && overflow) ||
                                 (op_a[WIDTH-1] != op_b[WIDTH-1] && result[WIDTH-1] != op_a[WIDTH-1]))
        else $error("sub overflow with inconsistent signs"); // R3
      AST_SUB_EQUAL_ZERO: assert (!((op_code == 4'd2 || op_code == 4'd3) && op_a == op_b) ||
                                  (zero && carry))
        else $error("equal operands not zero"); // R2
      AST_ZERO_FLAG: assert (!defined_op || (zero == (result == '0)))
        else $error("zero flag mismatch"); // R7
      AST_CMP_UPPER_CLEAR: assert (!(op_code == 4'd10 || op_code == 4'd11) ||
                                   (result[WIDTH-1:1] == '0))
        else $error("compare upper bits set"); // R5
      AST_LOGIC_FLAGS: assert (!logic_or_cmp || (!carry && !overflow))
        else $error("flags set in logic/compare"); // R8
      AST_UNUSED_QUIET: assert (defined_op || (result == '0 && !carry && !overflow && !zero))
        else $error("unused code not quiet"); // R9
    end
  end

endmodule

bind int_alu alu_checker #(.WIDTH(WIDTH)) u_chk (
  .op_a(op_a), .op_b(op_b), .op_code(op_code), .result(result),
  .carry(carry), .overflow(overflow), .zero(zero)
);

// File: tb/test_int_alu.sv
module test_int_alu;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 100000;

  logic        clk = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [3:0]  op_code = 4'd0;
  logic [31:0] result;
  logic        carry, overflow, zero;
  int          n_checks = 0;
  int          n_errors = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu i_int_alu (
    .op_a(op_a), .op_b(op_b), .op_code(op_code),
    .result(result), .carry(carry), .overflow(overflow), .zero(zero)
  );

  function automatic string res_tag(input logic [3:0] m);
    case (m)
      4'd0, 4'd1:   return "R1";
      4'd2, 4'd3:   return "R2";
      4'd4, 4'd5, 4'd6, 4'd7: return "R4";
      4'd10:        return "R5";
      4'd11:        return "R6";
      default:      return "R9";
    endcase
  endfunction

  function automatic logic is_defined(input logic [3:0] m);
    return (m <= 4'd7) || (m == 4'd10) || (m == 4'd11);
  endfunction

  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m,
                       output logic [31:0] s, output logic c, output logic v, output logic z);
    logic [32:0] t;
    s = '0; c = 1'b0; v = 1'b0;
    case (m)
      4'd0, 4'd1: begin
        t = {1'b0, a} + {1'b0, b};
        s = t[31:0]; c = t[32];
        v = (m == 4'd0) && (a[31] == b[31]) && (s[31] != a[31]);
      end
      4'd2, 4'd3: begin
        s = a - b; c = (a >= b);
        v = (m == 4'd2) && (a[31] != b[31]) && (s[31] != a[31]);
      end
      4'd4: s = a & b;
      4'd5: s = a | b;
      4'd6: s = a ^ b;
      4'd7: s = ~(a | b);
      4'd10: s = {31'd0, ($signed(a) < $signed(b))};
      4'd11: s = {31'd0, (a < b)};
      default: s = '0;
    endcase
    z = is_defined(m) && (s == 32'd0);
  endtask

  task automatic check1(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp, input logic [3:0] m);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s code=%0d a=%h b=%h actual=%h expected=%h",
               tag, what, m, op_a, op_b, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] m);
    logic [31:0] es;
    logic ec, ev, ez;
    string ftag, ctag, vtag;
    @(posedge clk);
    op_a = a; op_b = b; op_code = m;
    @(negedge clk);
    model(a, b, m, es, ec, ev, ez);
    ftag = res_tag(m);
    if (m <= 4'd3) begin
      ctag = ftag; vtag = "R3";
    end else if (is_defined(m)) begin
      ctag = "R8"; vtag = "R8";
    end else begin
      ctag = "R9"; vtag = "R9";
    end
    check1(ftag, "result", result, es, m);
    check1(ctag, "carry", {31'd0, carry}, {31'd0, ec}, m);
    check1(vtag, "overflow", {31'd0, overflow}, {31'd0, ev}, m);
    check1(is_defined(m) ? "R7" : "R9", "zero", {31'd0, zero}, {31'd0, ez}, m);
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // Idle state with all-zero inputs: signed add of 0 + 0 (R1, R7)
    @(negedge clk);
    check1("R1", "idle result", result, 32'd0, 4'd0);
    check1("R7", "idle zero", {31'd0, zero}, 32'd1, 4'd0);

    // Directed boundaries
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'd0);  // R3 positive overflow
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'd1);  // R3 unsigned never
    apply(32'h8000_0000, 32'h0000_0001, 4'd2);  // R3 negative overflow
    apply(32'h8000_0000, 32'h0000_0001, 4'd3);  // R2 no borrow
    apply(32'h0000_0000, 32'h0000_0000, 4'd2);  // R2 R7 zero difference
    apply(32'h0000_0000, 32'h0000_0001, 4'd3);  // R2 borrow
    apply(32'hFFFF_FFFF, 32'h0000_0001, 4'd1);  // R1 carry, zero result
    apply(32'h8000_0000, 32'h8000_0000, 4'd0);  // R3 two negatives
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'd0);  // R3 opposite signs
    apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, 4'd4);  // R4
    apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, 4'd5);
    apply(32'hF0F0_F0F0, 32'hF0F0_F0F0, 4'd6);  // R7 xor to zero
    apply(32'hFFFF_FFFF, 32'h0000_0000, 4'd7);  // R7 nor to zero
    apply(32'h8000_0000, 32'h0000_0001, 4'd10); // R5 overflowing compare
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'd10); // R5
    apply(32'h1234_5678, 32'h1234_5678, 4'd10); // R5 equal
    apply(32'h0000_0000, 32'hFFFF_FFFF, 4'd11); // R6
    apply(32'hFFFF_FFFF, 32'h0000_0000, 4'd11); // R6
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd8);  // R9
    apply(32'h0000_0000, 32'h0000_0000, 4'd12); // R9 zero stays low

    // Random sweep over all codes
    for (int m = 0; m < 16; m++) begin
      for (int n = 0; n < 150; n++) begin
        logic [31:0] ra, rb;
        ra = $urandom;
        rb = $urandom;
        if (n % 10 == 0) rb = ra;
        if (n % 10 == 1) ra = {ra[31], 31'd0};
        apply(ra, rb, 4'(m));
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule